// File: doc/BRIEF.md
# Half-Bridge Dead-Time and Bootstrap Precharge Sequencer

This block drives two half-bridge legs. Each channel takes one PWM command and turns it into a pair of complementary gate enables: a high-side enable and a low-side enable. A guard interval, during which both enables are low, separates every hand-over from one side to the other. A single configuration input sets how long that guard interval lasts. Any code other than all-ones sets a fixed number of clock counts, clamped into a legal window. The all-ones code selects adaptive operation. In adaptive operation the incoming side waits for a digital feedback flag, which reports that the outgoing driver's output has fallen below its low threshold. If that flag never arrives, the channel shuts itself off and raises a fault.

In the buck direction, the bootstrap supply of the high-side driver may be empty at start-up. Until a per-channel boot-ready input has been seen, the high side is held off. Each switching-period strobe then launches one fixed-width low-side pulse, which recharges the bootstrap capacitor. Once boot-ready has been seen, it is remembered until the channel is disabled, and the channel switches normally from then on. In the boost direction no precharge takes place, because the low side already charges the bootstrap supply when it switches.

The analog gate drivers, the threshold comparators and the bootstrap circuit are outside this block. They reach it only as digital status inputs. With the default parameters and a 100 MHz core clock, one count is 10 ns. The fixed guard interval then spans 20 ns to 250 ns, and a precharge pulse lasts 200 ns.

Top module: `hb_dtseq`

## Requirements
- R1: While `rst_n` is low, all of `hs_en`, `ls_en` and `fault` are low. When `chan_en[c]` is sampled 0 at a clock edge, `hs_en[c]`, `ls_en[c]` and `fault[c]` are low from that edge onward. The channel also forgets that boot-ready was seen.
- R2: `hs_en[c]` and `ls_en[c]` are never high in the same cycle.
- R3: Fixed mode applies when `dt_cfg` is not 8'hFF. Let D be the clamped `dt_cfg` value, in clock counts. Take an edge that samples a new `pwm[c]` value while one side conducts. At that edge the conducting enable falls. The other enable rises exactly D edges later (`pwm`=1 selects the high side, `pwm`=0 the low side). The first turn-on after enable also waits through this guard interval.
- R4: In fixed mode, `dt_cfg` values 0 and 1 act as 2. Values from 26 to 254 act as 25. Values from 2 to 25 are used as they are.
- R5: Adaptive mode applies when `dt_cfg` is 8'hFF. After the conducting enable falls, the other enable rises at the first edge that samples the outgoing side's low flag at 1. Turning on the high side waits on `ls_low[c]`; turning on the low side waits on `hs_low[c]`. A flag value of 1 means the output is low.
- R6: In adaptive mode, if the awaited low flag stays 0 for 64 guard cycles, `fault[c]` goes high at the 64th edge. Both enables of that channel then stay low, and `fault[c]` holds until the channel is disabled.
- R7: When `buck_dir`=1 and boot-ready has not yet been seen since the channel was enabled, `hs_en[c]` stays low. A `cyc_start` pulse that arrives while the channel is idle makes `ls_en[c]` high for exactly 20 cycles, starting at the edge that samples the strobe. Any strobe that arrives during a pulse is ignored.
- R8: Once `boot_ok[c]` has been sampled high, the channel switches normally, following `pwm[c]` with guard intervals inserted. This remains true after `boot_ok[c]` goes low again.
- R9: When `buck_dir`=0, no precharge pulses occur. The channel switches normally whatever `boot_ok` is, and `cyc_start` has no effect.
- R10: The two channels run independently of each other. A fault or precharge on one channel does not change the outputs of the other. The channels share only `dt_cfg`, `buck_dir` and `cyc_start`.
- R11: When a channel is disabled and then enabled again in the buck direction, precharge starts over. The high side is held off, and strobes produce pulses again, until `boot_ok[c]` is seen once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_en | input | 2 | Per-channel enable |
| pwm | input | 2 | Per-channel PWM command, 1 selects the high side |
| dt_cfg | input | 8 | Guard interval in counts; 8'hFF selects adaptive mode |
| buck_dir | input | 1 | 1 for buck direction, 0 for boost |
| boot_ok | input | 2 | Per-channel bootstrap supply above its undervoltage level |
| cyc_start | input | 1 | Strobe marking the start of each switching period |
| hs_low | input | 2 | High-side driver output is below its low threshold |
| ls_low | input | 2 | Low-side driver output is below its low threshold |
| hs_en | output | 2 | High-side gate enable |
| ls_en | output | 2 | Low-side gate enable |
| fault | output | 2 | Adaptive hand-over timed out |

## Verification
The bench measures the guard interval at each clamp boundary and just outside it. An off-by-one gap counter or a reversed clamp would show up as a guard interval one count short or long. In adaptive mode, the bench delays the feedback flag by several different lags. A design that switched on its own timer instead of the flag would get the lag wrong. The bench also holds one flag stuck low. A design with the wrong timeout, or one that let an enable rise after a fault, would show a fault at the wrong cycle or a gate turning on. For precharge, the bench counts the pulse width and sends a second strobe in the middle of a pulse. It also releases boot-ready again, and disables and re-enables a channel. These expose a stretched or retriggered pulse, a high side that turns on too early, a boot-ready that is not latched, and a precharge that never restarts.

// File: rtl/hb_dtseq_pkg.sv
`timescale 1ns/1ps
package hb_dtseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP_H,
    ST_GAP_L,
    ST_ON_H,
    ST_ON_L,
    ST_PRE,
    ST_FAULT
  } leg_state_t;

  // counter must hold the timeout, the precharge length and any gap code
  function automatic int ctr_width(int tmo, int pre, int dtw);
    int m;
    int w;
    m = (tmo > pre) ? tmo : pre;
    w = $clog2(m);
    return (w > dtw) ? w : dtw;
  endfunction

endpackage

// File: rtl/hb_dtseq_gapcfg.sv
`timescale 1ns/1ps
module hb_dtseq_gapcfg #(
  parameter int DTW        = 8,
  parameter int GMIN       = 2,
  parameter int GMAX       = 25,
  parameter int ADAPT_CODE = 255
) (
  input  logic [DTW-1:0] dt_cfg,
  output logic           adaptive,
  output logic [DTW-1:0] gap_last
);

  localparam logic [DTW-1:0] LO_C = DTW'(GMIN);
  localparam logic [DTW-1:0] HI_C = DTW'(GMAX);
  localparam logic [DTW-1:0] AD_C = DTW'(ADAPT_CODE);

  logic [DTW-1:0] gap_len;

  always_comb begin
    adaptive = (dt_cfg == AD_C);
    if (dt_cfg < LO_C)      gap_len = LO_C;
    else if (dt_cfg > HI_C) gap_len = HI_C;
    else                    gap_len = dt_cfg;
    gap_last = gap_len - DTW'(1);
  end

endmodule

// File: rtl/hb_dtseq_bootflag.sv
`timescale 1ns/1ps
module hb_dtseq_bootflag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic boot_ok,
  input  logic buck_dir,
  output logic pre_need,
  output logic ready
);

  logic rdy_q;
  logic rdy_d;

  always_comb begin
    rdy_d = en & (rdy_q | boot_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdy_q <= 1'b0;
    else if (rdy_d != rdy_q) rdy_q <= rdy_d;
  end

  assign ready    = rdy_q;
  assign pre_need = buck_dir & ~rdy_q;

endmodule

// File: rtl/hb_dtseq_leg.sv
`timescale 1ns/1ps
module hb_dtseq_leg
  import hb_dtseq_pkg::*;
#(
  parameter int DTW     = 8,
  parameter int CW      = 8,
  parameter int PRE_LEN = 20,
  parameter int TMO     = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           pwm,
  input  logic           adaptive,
  input  logic [DTW-1:0] gap_last,
  input  logic           pre_need,
  input  logic           cyc_start,
  input  logic           hs_low,
  input  logic           ls_low,
  output logic           hs_en,
  output logic           ls_en,
  output logic           fault
);

  localparam logic [CW-1:0] PRE_END = CW'(PRE_LEN - 1);
  localparam logic [CW-1:0] TMO_END = CW'(TMO - 1);

  leg_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_we;
  logic          opp_low;
  logic          hs_q, ls_q, flt_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_we  = 1'b0;
    opp_low = (st_q == ST_GAP_H) ? ls_low : hs_low;
    if (!en) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (pre_need) begin
            if (cyc_start) begin
              st_d   = ST_PRE;
              cnt_d  = '0;
              cnt_we = 1'b1;
            end
          end else begin
            st_d   = pwm ? ST_GAP_H : ST_GAP_L;
            cnt_d  = '0;
            cnt_we = 1'b1;
          end
        end
        ST_PRE: begin
          if (cnt_q == PRE_END) begin
            st_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q + CW'(1);
            cnt_we = 1'b1;
          end
        end
        ST_GAP_H, ST_GAP_L: begin
          if (pre_need) begin
            st_d = ST_IDLE;
          end else if (adaptive) begin
            if (opp_low) begin
              st_d = (st_q == ST_GAP_H) ? ST_ON_H : ST_ON_L;
            end else if (cnt_q == TMO_END) begin
              st_d = ST_FAULT;
            end else begin
              cnt_d  = cnt_q + CW'(1);
              cnt_we = 1'b1;
            end
          end else if (int'(cnt_q) >= int'(gap_last)) begin
            st_d = (st_q == ST_GAP_H) ? ST_ON_H : ST_ON_L;
          end else begin
            cnt_d  = cnt_q + CW'(1);
            cnt_we = 1'b1;
          end
        end
        ST_ON_H: begin
          if (pre_need) begin
            st_d = ST_IDLE;
          end else if (!pwm) begin
            st_d   = ST_GAP_L;
            cnt_d  = '0;
            cnt_we = 1'b1;
          end
        end
        ST_ON_L: begin
          if (pre_need) begin
            st_d = ST_IDLE;
          end else if (pwm) begin
            st_d   = ST_GAP_H;
            cnt_d  = '0;
            cnt_we = 1'b1;
          end
        end
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hs_q  <= (st_d == ST_ON_H);
      ls_q  <= (st_d == ST_ON_L) || (st_d == ST_PRE);
      flt_q <= (st_d == ST_FAULT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign hs_en = hs_q;
  assign ls_en = ls_q;
  assign fault = flt_q;

endmodule

// File: rtl/hb_dtseq.sv
`timescale 1ns/1ps
module hb_dtseq #(
  parameter int NCH        = 2,
  parameter int DTW        = 8,
  parameter int GMIN       = 2,
  parameter int GMAX       = 25,
  parameter int ADAPT_CODE = 255,
  parameter int PRE_LEN    = 20,
  parameter int TMO        = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] pwm,
  input  logic [DTW-1:0] dt_cfg,
  input  logic           buck_dir,
  input  logic [NCH-1:0] boot_ok,
  input  logic           cyc_start,
  input  logic [NCH-1:0] hs_low,
  input  logic [NCH-1:0] ls_low,
  output logic [NCH-1:0] hs_en,
  output logic [NCH-1:0] ls_en,
  output logic [NCH-1:0] fault
);

  localparam int CW = hb_dtseq_pkg::ctr_width(TMO, PRE_LEN, DTW);

  logic [1:0]     rs_q;
  logic           rst_core_n;
  logic           adaptive;
  logic [DTW-1:0] gap_last;
  logic [NCH-1:0] pre_need;
  logic [NCH-1:0] boot_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  hb_dtseq_gapcfg #(
    .DTW(DTW), .GMIN(GMIN), .GMAX(GMAX), .ADAPT_CODE(ADAPT_CODE)
  ) u_cfg (
    .dt_cfg(dt_cfg), .adaptive(adaptive), .gap_last(gap_last)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hb_dtseq_bootflag u_boot (
      .clk(clk), .rst_n(rst_core_n), .en(chan_en[c]), .boot_ok(boot_ok[c]),
      .buck_dir(buck_dir), .pre_need(pre_need[c]), .ready(boot_rdy[c])
    );

    hb_dtseq_leg #(
      .DTW(DTW), .CW(CW), .PRE_LEN(PRE_LEN), .TMO(TMO)
    ) u_leg (
      .clk(clk), .rst_n(rst_core_n), .en(chan_en[c]), .pwm(pwm[c]),
      .adaptive(adaptive), .gap_last(gap_last), .pre_need(pre_need[c]),
      .cyc_start(cyc_start), .hs_low(hs_low[c]), .ls_low(ls_low[c]),
      .hs_en(hs_en[c]), .ls_en(ls_en[c]), .fault(fault[c])
    );
  end

endmodule

// File: rtl/hb_dtseq_chk.sv
`timescale 1ns/1ps
module hb_dtseq_chk #(
  parameter int NCH = 2,
  parameter int TMO = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic           buck_dir,
  input logic [NCH-1:0] boot_rdy,
  input logic [NCH-1:0] hs_en,
  input logic [NCH-1:0] ls_en,
  input logic [NCH-1:0] fault
);

  localparam int OCW = $clog2(TMO + 2);

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == '0);

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(chan_en) & (hs_en | ls_en | fault)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [OCW-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_q <= '0;
      end else if (chan_en[c] && !hs_en[c] && !ls_en[c] && !fault[c]) begin
        if (off_q != '1) off_q <= off_q + OCW'(1);
      end else begin
        off_q <= '0;
      end
    end

    p_fault_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault[c]) |-> (int'(off_q) >= TMO));

    p_fault_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault[c] |-> (!hs_en[c] && !ls_en[c]));

    p_hs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (buck_dir && !boot_rdy[c]) |=> !hs_en[c]);
  end

endmodule

bind hb_dtseq hb_dtseq_chk #(.NCH(NCH), .TMO(TMO)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .chan_en(chan_en), .buck_dir(buck_dir),
  .boot_rdy(boot_rdy), .hs_en(hs_en), .ls_en(ls_en), .fault(fault)
);

// File: tb/hb_dtseq_test.sv
`timescale 1ns/1ps
module hb_dtseq_test;

  localparam int IDLE = 0, GH = 1, GL = 2, OH = 3, OL = 4, PRE = 5, FLT = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] chan_en, pwm, boot_ok, hs_low, ls_low;
  logic [7:0] dt_cfg;
  logic       buck_dir, cyc_start;
  logic [1:0] hs_en, ls_en, fault;

  int  total = 0;
  int  bad = 0;
  int  lag = 3;
  bit  stuck_h [2];
  bit  stuck_l [2];
  int  hoff [2];
  int  loff [2];
  int  m_st [2];
  int  m_el [2];
  bit  m_rdy [2];

  always #2 clk = ~clk;

  hb_dtseq uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pwm(pwm), .dt_cfg(dt_cfg),
    .buck_dir(buck_dir), .boot_ok(boot_ok), .cyc_start(cyc_start),
    .hs_low(hs_low), .ls_low(ls_low), .hs_en(hs_en), .ls_en(ls_en), .fault(fault)
  );

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_st[c] = IDLE; m_el[c] = 0; m_rdy[c] = 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int d;
        bit ad, need, opp, toh;
        ad   = (dt_cfg == 8'hFF);
        d    = (dt_cfg < 2) ? 2 : ((dt_cfg > 25) ? 25 : int'(dt_cfg));
        need = buck_dir && !m_rdy[c];
        if (!chan_en[c]) begin
          m_st[c] = IDLE; m_el[c] = 0; m_rdy[c] = 1'b0;
        end else begin
          case (m_st[c])
            IDLE: begin
              if (need) begin
                if (cyc_start) begin m_st[c] = PRE; m_el[c] = 0; end
              end else begin
                m_st[c] = pwm[c] ? GH : GL; m_el[c] = 0;
              end
            end
            PRE: if (m_el[c] == 19) m_st[c] = IDLE; else m_el[c]++;
            GH, GL: begin
              toh = (m_st[c] == GH);
              opp = toh ? ls_low[c] : hs_low[c];
              if (need) m_st[c] = IDLE;
              else if (ad) begin
                if (opp) m_st[c] = toh ? OH : OL;
                else if (m_el[c] == 63) m_st[c] = FLT;
                else m_el[c]++;
              end else if (m_el[c] >= d - 1) m_st[c] = toh ? OH : OL;
              else m_el[c]++;
            end
            OH: if (need) m_st[c] = IDLE; else if (!pwm[c]) begin m_st[c] = GL; m_el[c] = 0; end
            OL: if (need) m_st[c] = IDLE; else if (pwm[c]) begin m_st[c] = GH; m_el[c] = 0; end
            default: ;
          endcase
          m_rdy[c] = m_rdy[c] | boot_ok[c];
        end
      end
    end
  end

  function automatic string tag_of(int c);
    if (!chan_en[c])         return "R1";
    if (m_st[c] == PRE)      return "R7";
    if (m_st[c] == FLT)      return "R6";
    if (m_st[c] == GH || m_st[c] == GL)
      return (dt_cfg == 8'hFF) ? "R5" : "R3";
    return buck_dir ? "R8" : "R9";
  endfunction

  // per-cycle comparison, then gate-feedback emulation
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        int exp_v, act_v;
        exp_v = {m_st[c] == FLT, (m_st[c] == OL) || (m_st[c] == PRE), m_st[c] == OH};
        act_v = {fault[c], ls_en[c], hs_en[c]};
        chk(tag_of(c), act_v, exp_v, $sformatf("ch%0d {fault,ls,hs}", c));
        chk("R2", int'(hs_en[c] & ls_en[c]), 0, $sformatf("ch%0d overlap", c));
      end
    end
    for (int c = 0; c < 2; c++) begin
      hoff[c] = hs_en[c] ? 0 : ((hoff[c] < 1000) ? hoff[c] + 1 : hoff[c]);
      loff[c] = ls_en[c] ? 0 : ((loff[c] < 1000) ? loff[c] + 1 : loff[c]);
      hs_low[c] = !stuck_h[c] && (hoff[c] >= lag);
      ls_low[c] = !stuck_l[c] && (loff[c] >= lag);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // toggle pwm of one channel and count guard cycles until the new side is on
  task automatic flip(int c, int exp, string tag);
    logic tgt;
    int   n;
    tgt = ~pwm[c];
    @(negedge clk);
    pwm[c] = tgt;
    n = 0;
    @(negedge clk);
    while (((tgt ? hs_en[c] : ls_en[c]) == 1'b0) && n < 300) begin
      n++;
      @(negedge clk);
    end
    chk(tag, n, exp, $sformatf("ch%0d guard cycles", c));
    cyc(4);
  endtask

  task automatic strobe();
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
  endtask

  task automatic pulse_width(int c, string tag, bit mid_strobe);
    int n;
    strobe();
    n = 0;
    while (ls_en[c] && n < 100) begin
      n++;
      cyc_start = mid_strobe && (n == 5);
      @(negedge clk);
    end
    cyc_start = 1'b0;
    chk(tag, n, 20, $sformatf("ch%0d precharge width", c));
  endtask

  initial begin
    int n;
    for (int c = 0; c < 2; c++) begin
      hoff[c] = 1000; loff[c] = 1000; stuck_h[c] = 0; stuck_l[c] = 0;
    end
    hs_low = 2'b11; ls_low = 2'b11;
    rst_n = 1'b0; chan_en = 2'b00; pwm = 2'b00; dt_cfg = 8'd10;
    buck_dir = 1'b0; boot_ok = 2'b00; cyc_start = 1'b0;
    cyc(5);
    chk("R1", int'({hs_en, ls_en, fault}), 0, "outputs in reset");
    rst_n = 1'b1;
    cyc(4);
    chk("R1", int'({hs_en, ls_en, fault}), 0, "outputs after reset");

    // boost direction, fixed guard interval
    chan_en = 2'b11;
    cyc(30);
    chk("R9", int'(ls_en), 3, "boost low sides on without boot");
    strobe();
    cyc(25);
    chk("R9", int'(ls_en), 3, "strobe ignored in boost");
    flip(0, 10, "R3");
    flip(0, 10, "R3");
    flip(1, 10, "R3");
    chk("R10", int'(ls_en[1]), 0, "ch1 unaffected by ch0 flips");
    dt_cfg = 8'd0;   flip(0, 2, "R4");
    dt_cfg = 8'd1;   flip(0, 2, "R4");
    dt_cfg = 8'd2;   flip(0, 2, "R4");
    dt_cfg = 8'd25;  flip(0, 25, "R4");
    dt_cfg = 8'd26;  flip(0, 25, "R4");
    dt_cfg = 8'd254; flip(0, 25, "R4");

    // adaptive mode
    dt_cfg = 8'hFF; lag = 3;
    flip(0, 3, "R5");
    flip(0, 3, "R5");
    lag = 6;
    flip(1, 6, "R5");
    flip(1, 6, "R5");

    // timeout on a stuck flag, ch0 currently low side on
    chk("R6", int'(ls_en[0]), 1, "ch0 low side before timeout");
    stuck_l[0] = 1;
    @(negedge clk); pwm[0] = 1'b1;
    n = 0;
    @(negedge clk);
    while (!fault[0] && n < 300) begin n++; @(negedge clk); end
    chk("R6", n, 64, "cycles until fault");
    flip(1, 6, "R10");
    chk("R6", int'({hs_en[0], ls_en[0], fault[0]}), 1, "faulted channel off and latched");
    stuck_l[0] = 0;
    cyc(5);
    chk("R6", int'(fault[0]), 1, "fault held after flag recovers");
    chan_en[0] = 1'b0;
    cyc(2);
    chk("R1", int'(fault[0]), 0, "fault cleared by disable");

    // buck start-up with precharge
    dt_cfg = 8'd10; chan_en = 2'b00; buck_dir = 1'b1; pwm = 2'b11;
    cyc(3);
    chan_en = 2'b11;
    cyc(10);
    chk("R7", int'({hs_en, ls_en}), 0, "high side held, no pulse yet");
    pulse_width(0, "R7", 1'b0);
    pulse_width(1, "R7", 1'b1);
    cyc(30);
    chk("R7", int'(ls_en), 0, "mid-pulse strobe gave no extra pulse");
    chk("R7", int'(hs_en), 0, "high side still held");
    boot_ok[0] = 1'b1;
    cyc(30);
    chk("R8", int'(hs_en[0]), 1, "ch0 high side after boot ready");
    chk("R10", int'(hs_en[1]), 0, "ch1 still held");
    boot_ok[0] = 1'b0;
    cyc(10);
    chk("R8", int'(hs_en[0]), 1, "boot ready remembered");
    flip(0, 10, "R8");
    flip(0, 10, "R8");

    // restart of precharge after disable
    chan_en[0] = 1'b0;
    cyc(2);
    chan_en[0] = 1'b1;
    cyc(20);
    chk("R11", int'(hs_en[0]), 0, "high side held after re-enable");
    pulse_width(0, "R11", 1'b0);
    cyc(5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule